// File: doc/BRIEF.md
# Latency-Scheduled Writeback Queue

This block schedules result writeback for an in-order processor that has no interlocks. Each compute instruction hands over its result together with a fixed latency. The block parks that result in a circular ring of slots, at the slot that becomes due that many advancing issues later. Each advancing issue reads the slot now at the head of the ring and drives it onto the register-file write port. The destination register comes from the instruction being issued in that cycle, not from the instruction that produced the value.

A second write port carries host writes to the register file through the block. When the host and the scheduled writeback aim at the same register in the same cycle, the host write is suppressed so that the writeback wins.

An output-class instruction ends the vertex program. It leaves the ring untouched. A saturating debug counter records each case where a scheduled result lands on a slot that still holds a nonzero value.

Top module: `wbq_sched`

## Requirements
- R1: After reset every slot holds zero, the head is at slot 0 and `coll_cnt` is 0. Advancing issues made straight after reset read zero for a whole ring revolution.
- R2: In an advancing issue (class 0, 1 or 3) with a nonzero `iss_dst`, `wb_we` is 1, `wb_addr` equals `iss_dst` and `wb_data` is the head slot, all in the same cycle. A destination of 0 gives `wb_we` = 0.
- R3: A result issued with latency L (1 to NSLOT) becomes the head value on the L-th advancing issue after its own. A latency of 0 behaves as NSLOT.
- R4: Each advancing issue clears the slot it reads, so a result is delivered once. That slot reads zero a full revolution later unless it has been refilled.
- R5: Class code 0 (no-op) advances and clears the head and writes back if its destination is nonzero, but it stores no result.
- R6: Class code 2 (output) performs no writeback and does not move, clear or fill the ring. `prog_end` is 1 in that cycle.
- R7: With `iss_vld` low there is no writeback, `prog_end` is 0 and the ring state does not change.
- R8: When two results are scheduled into the same slot, the one issued later replaces the earlier.
- R9: `coll_cnt` rises by one, on the clock edge of the storing issue, when a result is stored into a slot that holds a nonzero value other than the head slot being read. Storing into a zero slot, or into the head slot as it is cleared, does not count. The counter stops at 2^CNTW-1.
- R10: `hw_we`/`hw_addr`/`hw_data` follow the host inputs in the same cycle. The exception is a host write whose address equals an active writeback's `wb_addr`: `hw_we` is then 0. Writes to different registers pass together.
- R11: Class code 3 is a second compute class and schedules its result exactly as class 1 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_cls | input | 2 | Class: 0 no-op, 1 compute, 2 output, 3 compute |
| iss_lat | input | LATW | Result latency in advancing issues |
| iss_res | input | DW | Result value to schedule |
| iss_dst | input | AW | Register receiving the value due now |
| host_we | input | 1 | Host register write request |
| host_addr | input | AW | Host write register index |
| host_data | input | DW | Host write data |
| wb_we | output | 1 | Scheduled writeback enable |
| wb_addr | output | AW | Scheduled writeback register |
| wb_data | output | DW | Scheduled writeback value |
| hw_we | output | 1 | Host write enable after arbitration |
| hw_addr | output | AW | Host write register |
| hw_data | output | DW | Host write data |
| prog_end | output | 1 | Output instruction issued, program ends |
| coll_cnt | output | CNTW | Saturating slot overwrite counter |

## Verification
The bench builds the block with NSLOT=7, DW=32, AW=7 and CNTW=3. Seven slots is not a power of two, and a latency of seven lands on the head slot as it is cleared. Together these exercise the modulo reduction of the slot index and the exception for that slot in the overwrite counter. The three-bit counter reaches saturation after a handful of overlapping schedules, so the bench can also show that it holds at its limit.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  typedef enum logic [1:0] {
    CLS_NOP  = 2'd0,
    CLS_EXEC = 2'd1,
    CLS_OUT  = 2'd2,
    CLS_ALT  = 2'd3
  } wbq_cls_e;
endpackage

// File: rtl/wbq_rst_sync.sv
module wbq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/wbq_ring.sv
module wbq_ring #(
  parameter int NSLOT = 7,
  parameter int DW    = 32,
  parameter int LATW  = 3,
  localparam int HW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            ins,
  input  logic [LATW-1:0] lat,
  input  logic [DW-1:0]   res,
  output logic [DW-1:0]   head_val,
  output logic            coll
);
  localparam int SW = HW + LATW + 1;
  localparam logic [SW-1:0] N_S  = SW'(NSLOT);
  localparam logic [HW-1:0] LAST = HW'(NSLOT - 1);

  logic [HW-1:0] head_q;
  logic [HW-1:0] head_d;
  logic [HW-1:0] idx;
  logic [SW-1:0] sum0;
  logic [SW-1:0] sum1;
  logic [SW-1:0] sum2;
  logic [NSLOT-1:0][DW-1:0] slot_vec;

  // target slot: head + latency, reduced modulo NSLOT (latency 0 == NSLOT)
  always_comb begin
    sum0 = SW'(head_q) + SW'(lat);
    sum1 = (sum0 >= N_S) ? (sum0 - N_S) : sum0;
    sum2 = (sum1 >= N_S) ? (sum1 - N_S) : sum1;
    idx  = sum2[HW-1:0];
  end

  always_comb begin
    head_d = head_q;
    if (adv) begin
      head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (adv) begin
      head_q <= head_d;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [HW-1:0] GI = HW'(g);
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic          en;

    // clear on read, then a store into the same slot takes precedence
    always_comb begin
      en = 1'b0;
      d  = q;
      if (adv && (head_q == GI)) begin
        en = 1'b1;
        d  = '0;
      end
      if (ins && (idx == GI)) begin
        en = 1'b1;
        d  = res;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign slot_vec[g] = q;
  end

  assign head_val = slot_vec[head_q];
  assign coll     = ins && (idx != head_q) && (slot_vec[idx] != '0);

  // R1
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_q <= LAST);

  // R4
  head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && head_q == LAST) |=> (head_q == '0));

  // R4
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && head_q != LAST) |=> (head_q == $past(head_q) + 1'b1));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(head_q));
endmodule

// File: rtl/wbq_wport.sv
module wbq_wport #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_req,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data,
  output logic          wb_we,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          hw_we,
  output logic [AW-1:0] hw_addr,
  output logic [DW-1:0] hw_data
);
  logic clash;

  always_comb begin
    clash   = wb_req && (host_addr == wb_addr_i);
    wb_we   = wb_req;
    wb_addr = wb_addr_i;
    wb_data = wb_data_i;
    hw_we   = host_we && !clash;
    hw_addr = host_addr;
    hw_data = host_data;
  end

  // R10
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && wb_we) |-> (hw_addr != wb_addr));

  // R2
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_addr != '0));
endmodule

// File: rtl/wbq_ccnt.sv
module wbq_ccnt #(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [CNTW-1:0] cnt
);
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CMAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX) |=> (cnt == CMAX));

  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wbq_sched.sv
module wbq_sched
  import wbq_pkg::*;
#(
  parameter int NSLOT = 7,
  parameter int DW    = 32,
  parameter int AW    = 7,
  parameter int CNTW  = 16,
  localparam int LATW = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic [1:0]      iss_cls,
  input  logic [LATW-1:0] iss_lat,
  input  logic [DW-1:0]   iss_res,
  input  logic [AW-1:0]   iss_dst,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_data,
  output logic            wb_we,
  output logic [AW-1:0]   wb_addr,
  output logic [DW-1:0]   wb_data,
  output logic            hw_we,
  output logic [AW-1:0]   hw_addr,
  output logic [DW-1:0]   hw_data,
  output logic            prog_end,
  output logic [CNTW-1:0] coll_cnt
);
  wbq_cls_e      cls;
  logic          rst_sn;
  logic          is_out;
  logic          adv;
  logic          ins;
  logic          wb_req;
  logic          coll;
  logic [DW-1:0] head_val;

  always_comb begin
    cls      = wbq_cls_e'(iss_cls);
    is_out   = (cls == CLS_OUT);
    adv      = iss_vld && !is_out;
    ins      = adv && (cls != CLS_NOP);
    wb_req   = adv && (iss_dst != '0);
    prog_end = iss_vld && is_out;
  end

  wbq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  wbq_ring #(
    .NSLOT (NSLOT),
    .DW    (DW),
    .LATW  (LATW)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_sn),
    .adv      (adv),
    .ins      (ins),
    .lat      (iss_lat),
    .res      (iss_res),
    .head_val (head_val),
    .coll     (coll)
  );

  wbq_wport #(
    .DW (DW),
    .AW (AW)
  ) u_wport (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wb_req    (wb_req),
    .wb_addr_i (iss_dst),
    .wb_data_i (head_val),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_data (host_data),
    .wb_we     (wb_we),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .hw_we     (hw_we),
    .hw_addr   (hw_addr),
    .hw_data   (hw_data)
  );

  wbq_ccnt #(
    .CNTW (CNTW)
  ) u_ccnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .inc   (coll),
    .cnt   (coll_cnt)
  );

  // R6
  out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (iss_vld && is_out) |=> $stable(head_val));

  // R7
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !iss_vld |=> $stable(head_val));

  // R6
  out_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    prog_end |-> !wb_we);

  // R9
  coll_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    coll |-> (iss_vld && !is_out && cls != CLS_NOP));
endmodule

// File: tb/wbq_sched_test.sv
`timescale 1ns/1ps
module wbq_sched_test;
  localparam int NS = 7;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int CW = 3;
  localparam int LW = 3;
  localparam int CMAX = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_vld;
  logic [1:0]    iss_cls;
  logic [LW-1:0] iss_lat;
  logic [DW-1:0] iss_res;
  logic [AW-1:0] iss_dst;
  logic          host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_data;
  logic          wb_we;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          hw_we;
  logic [AW-1:0] hw_addr;
  logic [DW-1:0] hw_data;
  logic          prog_end;
  logic [CW-1:0] coll_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_coll = 0;

  always #2.5 clk = ~clk;

  wbq_sched #(.NSLOT(NS), .DW(DW), .AW(AW), .CNTW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls),
    .iss_lat(iss_lat), .iss_res(iss_res), .iss_dst(iss_dst),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .hw_we(hw_we), .hw_addr(hw_addr), .hw_data(hw_data),
    .prog_end(prog_end), .coll_cnt(coll_cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, outputs settle 1 ns later
  task automatic drive(input logic v, input logic [1:0] c, input int lat,
                       input logic [31:0] r, input int d);
    @(negedge clk);
    iss_vld = v;
    iss_cls = c;
    iss_lat = LW'(lat);
    iss_res = r;
    iss_dst = AW'(d);
    #1;
  endtask

  task automatic bump_coll();
    if (exp_coll < CMAX) exp_coll++;
  endtask

  task automatic t_reset();
    drive(1'b0, 2'd0, 0, 0, 0);
    chk("R1 coll_cnt after reset", 32'(coll_cnt), 0);
    chk("R7 wb_we idle", 32'(wb_we), 0);
    chk("R7 prog_end idle", 32'(prog_end), 0);
    for (int k = 0; k < NS; k++) begin
      drive(1'b1, 2'd0, 0, 0, 1);
      chk("R1 empty slot after reset", wb_data, 0);
      chk("R5 nop writes back", 32'(wb_we), 1);
    end
  endtask

  task automatic t_latency();
    for (int l = 0; l <= NS; l++) begin
      int lx;
      logic [31:0] rv;
      lx = (l == 0) ? NS : l;
      rv = 32'h100 + 32'(l);
      drive(1'b1, 2'd1, l, rv, 3);
      chk("R2 wb_addr on compute", 32'(wb_addr), 3);
      for (int k = 1; k <= 2 * NS; k++) begin
        drive(1'b1, 2'd0, 0, 32'hdead, 4);
        if (k <= lx) chk("R3 latency delivery", wb_data, (k == lx) ? rv : 32'h0);
        else         chk("R4 slot cleared after read", wb_data, 0);
      end
    end
    chk("R9 no count on empty slots", 32'(coll_cnt), 32'(exp_coll));
  endtask

  task automatic t_dest0();
    drive(1'b1, 2'd1, 1, 32'h0000_00aa, 0);
    chk("R2 dest zero no write", 32'(wb_we), 0);
    drive(1'b1, 2'd0, 0, 0, 2);
    chk("R2 wb_we", 32'(wb_we), 1);
    chk("R2 wb_addr", 32'(wb_addr), 2);
    chk("R2 wb_data", wb_data, 32'h0000_00aa);
  endtask

  task automatic t_head_refill();
    drive(1'b1, 2'd1, 1, 32'h0000_d00d, 0);
    drive(1'b1, 2'd1, NS, 32'h0000_e00e, 6);
    chk("R3 head value read", wb_data, 32'h0000_d00d);
    chk("R2 head value addr", 32'(wb_addr), 6);
    for (int k = 1; k <= NS; k++) begin
      drive(1'b1, 2'd0, 0, 0, 1);
      if (k == 1) chk("R9 head refill not counted", 32'(coll_cnt), 32'(exp_coll));
      chk("R3 full-ring latency", wb_data, (k == NS) ? 32'h0000_e00e : 32'h0);
    end
  endtask

  task automatic t_output();
    drive(1'b1, 2'd1, 2, 32'h0000_0a0a, 0);
    drive(1'b0, 2'd1, 1, 32'hffff_ffff, 5);
    chk("R7 idle no write", 32'(wb_we), 0);
    chk("R7 idle no end", 32'(prog_end), 0);
    drive(1'b1, 2'd2, 1, 32'hffff_ffff, 5);
    chk("R6 output no write", 32'(wb_we), 0);
    chk("R6 output ends program", 32'(prog_end), 1);
    drive(1'b0, 2'd0, 0, 0, 0);
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R6 ring not advanced 1", wb_data, 0);
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R6 ring not advanced 2", wb_data, 32'h0000_0a0a);
  endtask

  task automatic t_overwrite();
    drive(1'b1, 2'd1, 3, 32'h0000_0b0b, 0);
    drive(1'b1, 2'd1, 2, 32'h0000_0c0c, 0);
    bump_coll();
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R8 intermediate slot", wb_data, 0);
    chk("R9 collision counted", 32'(coll_cnt), 32'(exp_coll));
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R8 later result wins", wb_data, 32'h0000_0c0c);
    drive(1'b1, 2'd1, 3, 32'h0, 0);
    drive(1'b1, 2'd1, 2, 32'h0000_0c0d, 0);
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R9 zero slot not counted", 32'(coll_cnt), 32'(exp_coll));
    drive(1'b1, 2'd0, 0, 0, 1);
    chk("R8 store over zero", wb_data, 32'h0000_0c0d);
  endtask

  task automatic t_saturate();
    for (int p = 0; p < CMAX + 2; p++) begin
      drive(1'b1, 2'd1, 3, 32'h1, 0);
      drive(1'b1, 2'd1, 2, 32'h2, 0);
      bump_coll();
      drive(1'b1, 2'd0, 0, 0, 0);
      chk("R9 count step", 32'(coll_cnt), 32'(exp_coll));
      drive(1'b1, 2'd0, 0, 0, 0);
    end
    chk("R9 counter saturated", 32'(coll_cnt), CMAX);
  endtask

  task automatic t_alt_class();
    drive(1'b1, 2'd3, 1, 32'h0000_f00f, 0);
    drive(1'b1, 2'd0, 0, 0, 7);
    chk("R11 class 3 schedules result", wb_data, 32'h0000_f00f);
  endtask

  task automatic t_host();
    host_we = 1'b1;
    host_addr = AW'(9);
    host_data = 32'h1234_5678;
    drive(1'b0, 2'd0, 0, 0, 0);
    chk("R10 host pass we", 32'(hw_we), 1);
    chk("R10 host pass addr", 32'(hw_addr), 9);
    chk("R10 host pass data", hw_data, 32'h1234_5678);
    drive(1'b1, 2'd0, 0, 0, 9);
    chk("R10 same reg host dropped", 32'(hw_we), 0);
    chk("R10 same reg writeback kept", 32'(wb_we), 1);
    drive(1'b1, 2'd0, 0, 0, 8);
    chk("R10 other reg host kept", 32'(hw_we), 1);
    chk("R10 other reg writeback kept", 32'(wb_we), 1);
    drive(1'b1, 2'd2, 0, 0, 9);
    chk("R10 output class host kept", 32'(hw_we), 1);
    host_we = 1'b0;
    drive(1'b0, 2'd0, 0, 0, 0);
    chk("R10 host idle", 32'(hw_we), 0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_vld = 1'b0;
    iss_cls = 2'd0;
    iss_lat = '0;
    iss_res = '0;
    iss_dst = '0;
    host_we = 1'b0;
    host_addr = '0;
    host_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_dest0();
    t_head_refill();
    t_output();
    t_overwrite();
    t_saturate();
    t_alt_class();
    t_host();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule